// File: doc/BRIEF.md
# Pulse-Gap Downlink Transmitter for a 125 kHz Reader Field

This block turns one tag command into the on/off pattern of a 125 kHz reader field. Every timing is counted in carrier periods of 8 µs, delivered to the block as a one-clock `tick` strobe. A command carries a two-bit opcode, a page bit, an optional 32-bit password, a lock bit, 32 data bits, a 3-bit block address and a write/read flag. Once accepted, the block keeps the field on long enough for the tag to load its configuration. It then opens a long start gap and sends every command bit as a field-on interval whose length gives the bit value, each followed by a short field-off gap.

Commands enter through a valid/ready pair. `cmd_ready` is high only while the block is idle. A command is taken on the rising clock edge where `cmd_valid` and `cmd_ready` are both high. There is no queue, so the source holds a command until it is taken. Anything presented while the block is busy is never taken and has no effect. After a write, `done` pulses for one clock. After a read, the field stays on for a settle interval and then `done` and `capture_en` pulse together, so the receive path can start capturing the tag reply.

Top module: `pgap_downlink_tx`

## Requirements
- R1: After reset `field_on` is 0, `cmd_ready` is 1, and `done` and `capture_en` are 0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next clock `cmd_ready` is 0, and it is 1 again in the cycle where `done` is 1.
- R3: Once a command is taken, `field_on` is 1 for HOLD_TICKS ticks (default 8375, about 67 ms) and then 0 for START_TICKS ticks (default 50).
- R4: A 0 bit is `field_on`=1 for ZERO_TICKS ticks (default 24) and a 1 bit is `field_on`=1 for ONE_TICKS ticks (default 54). Each bit is followed by `field_on`=0 for GAP_TICKS ticks (default 20).
- R5: Bit order on the field is as follows. The opcode comes first, `cmd_op[1]` before `cmd_op[0]`, followed by `cmd_page`. The 32 password bits follow, MSB first, only when `cmd_pwd_en`=1. On a write (`cmd_write`=1) the lock bit comes next, then the 32 data bits MSB first. The 3 address bits come last, MSB first.
- R6: On a write, `done` is 1 for exactly one clock, in the cycle after the tick that ends the last gap. `capture_en` stays 0 throughout.
- R7: On a read, the field is on for SETTLE_TICKS ticks (default 150) after the last gap. `done` and `capture_en` are then both 1 for the same single clock.
- R8: The timing advances only on clocks where `tick` is 1. While `tick` is 0, `field_on` holds its value and `done` stays 0.
- R9: While the block is busy, `cmd_valid` and the command inputs have no effect. No second command starts after the current one finishes unless `cmd_valid` is high at or after the `done` cycle.
- R10: While idle, `field_on` is 0 until the first command completes. After that it is 1, starting in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock strobe per 8 µs carrier period |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_op | input | 2 | Opcode bits, bit 1 sent first |
| cmd_page | input | 1 | Page select bit |
| cmd_pwd_en | input | 1 | Send the password field |
| cmd_pwd | input | 32 | Password, MSB first |
| cmd_lock | input | 1 | Lock bit (writes only) |
| cmd_data | input | 32 | Data word, MSB first (writes only) |
| cmd_addr | input | 3 | Block address, MSB first |
| field_on | output | 1 | Reader field enable |
| done | output | 1 | One-clock end-of-command pulse |
| capture_en | output | 1 | One-clock pulse starting reply capture after a read |

## Verification
A wrong phase counter or an off-by-one load shows at `field_on` as an interval that is one tick too long or too short, in the same phase. A shift register that is out of step shows as a wrong on-time in the next bit slot. The bench compares `field_on` against a model, counting in ticks, so any such fault is reported at the first tick where it shows and not only at the end. A wrong latched read/write flag shows at completion, either as a missing settle interval or as `capture_en` pulsing on a write. The bench also runs random tick gaps, which show up any state that moves without a tick.

// File: rtl/pgap_pkg.sv
package pgap_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_HOLD   = 3'd1,
    PH_START  = 3'd2,
    PH_MARK   = 3'd3,
    PH_SPACE  = 3'd4,
    PH_SETTLE = 3'd5
  } phase_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgap_frame_build.sv
module pgap_frame_build #(
  parameter int OP_W    = 2,
  parameter int PWD_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int FRAME_W = OP_W + 1 + PWD_W + 1 + DATA_W + ADDR_W,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               wr,
  input  logic               pwd_en,
  input  logic [OP_W-1:0]    op,
  input  logic               page,
  input  logic [PWD_W-1:0]   pwd,
  input  logic               lock,
  input  logic [DATA_W-1:0]  data,
  input  logic [ADDR_W-1:0]  addr,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);
  localparam int WRF_W = 1 + DATA_W;

  // first bit to send sits in the MSB; unused tail is zero
  always_comb begin
    unique case ({wr, pwd_en})
      2'b11: begin
        frame = {op, page, pwd, lock, data, addr};
        len   = LEN_W'(FRAME_W);
      end
      2'b10: begin
        frame = {op, page, lock, data, addr, {PWD_W{1'b0}}};
        len   = LEN_W'(FRAME_W - PWD_W);
      end
      2'b01: begin
        frame = {op, page, pwd, addr, {WRF_W{1'b0}}};
        len   = LEN_W'(FRAME_W - WRF_W);
      end
      default: begin
        frame = {op, page, addr, {(PWD_W + WRF_W){1'b0}}};
        len   = LEN_W'(FRAME_W - WRF_W - PWD_W);
      end
    endcase
  end
endmodule

// File: rtl/pgap_bit_shift.sv
module pgap_bit_shift #(
  parameter int FRAME_W = 71,
  parameter int LEN_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   len_in,
  input  logic               shift,
  output logic               cur_bit,
  output logic               empty
);
  logic [FRAME_W-1:0] sreg;
  logic [LEN_W-1:0]   left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= frame_in;
      left <= len_in;
    end else if (shift && left != '0) begin
      sreg <= {sreg[FRAME_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign cur_bit = sreg[FRAME_W-1];
  assign empty   = (left == '0);
endmodule

// File: rtl/pgap_phase_timer.sv
module pgap_phase_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  // a phase loaded with N-1 lasts exactly N ticks
  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expire = tick && (cnt == '0);
endmodule

// File: rtl/pgap_seq_ctrl.sv
module pgap_seq_ctrl
  import pgap_pkg::*;
#(
  parameter int CNT_W        = 14,
  parameter int HOLD_TICKS   = 8375,
  parameter int START_TICKS  = 50,
  parameter int ZERO_TICKS   = 24,
  parameter int ONE_TICKS    = 54,
  parameter int GAP_TICKS    = 20,
  parameter int SETTLE_TICKS = 150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic             expire,
  input  logic             cur_bit,
  input  logic             empty,
  output logic             cmd_ready,
  output logic             tm_load,
  output logic [CNT_W-1:0] tm_val,
  output logic             sh_load,
  output logic             sh_shift,
  output logic             field_on,
  output logic             done,
  output logic             capture_en
);
  localparam logic [CNT_W-1:0] L_HOLD   = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] L_START  = CNT_W'(START_TICKS - 1);
  localparam logic [CNT_W-1:0] L_ZERO   = CNT_W'(ZERO_TICKS - 1);
  localparam logic [CNT_W-1:0] L_ONE    = CNT_W'(ONE_TICKS - 1);
  localparam logic [CNT_W-1:0] L_GAP    = CNT_W'(GAP_TICKS - 1);
  localparam logic [CNT_W-1:0] L_SETTLE = CNT_W'(SETTLE_TICKS - 1);

  phase_t state, nxt;
  logic   is_read;
  logic   park;
  logic   fin, fin_rd;

  always_comb begin
    nxt      = state;
    tm_load  = 1'b0;
    tm_val   = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    fin      = 1'b0;
    fin_rd   = 1'b0;
    unique case (state)
      PH_IDLE: if (cmd_valid) begin
        nxt     = PH_HOLD;
        tm_load = 1'b1;
        tm_val  = L_HOLD;
        sh_load = 1'b1;
      end
      PH_HOLD: if (expire) begin
        nxt     = PH_START;
        tm_load = 1'b1;
        tm_val  = L_START;
      end
      PH_START: if (expire) begin
        nxt     = PH_MARK;
        tm_load = 1'b1;
        tm_val  = cur_bit ? L_ONE : L_ZERO;
      end
      PH_MARK: if (expire) begin
        nxt      = PH_SPACE;
        tm_load  = 1'b1;
        tm_val   = L_GAP;
        sh_shift = 1'b1;
      end
      PH_SPACE: if (expire) begin
        if (!empty) begin
          nxt     = PH_MARK;
          tm_load = 1'b1;
          tm_val  = cur_bit ? L_ONE : L_ZERO;
        end else if (is_read) begin
          nxt     = PH_SETTLE;
          tm_load = 1'b1;
          tm_val  = L_SETTLE;
        end else begin
          nxt = PH_IDLE;
          fin = 1'b1;
        end
      end
      PH_SETTLE: if (expire) begin
        nxt    = PH_IDLE;
        fin    = 1'b1;
        fin_rd = 1'b1;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      is_read    <= 1'b0;
      park       <= 1'b0;
      done       <= 1'b0;
      capture_en <= 1'b0;
    end else begin
      state      <= nxt;
      done       <= fin;
      capture_en <= fin_rd;
      if (fin) park <= 1'b1;
      if (state == PH_IDLE && cmd_valid) is_read <= !cmd_write;
    end
  end

  assign cmd_ready = (state == PH_IDLE);
  assign field_on  = (state == PH_HOLD) || (state == PH_MARK) ||
                     (state == PH_SETTLE) || (state == PH_IDLE && park);
endmodule

// File: rtl/pgap_downlink_tx.sv
module pgap_downlink_tx
  import pgap_pkg::*;
#(
  parameter int OP_W         = 2,
  parameter int PWD_W        = 32,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 3,
  parameter int HOLD_TICKS   = 8375,
  parameter int START_TICKS  = 50,
  parameter int ZERO_TICKS   = 24,
  parameter int ONE_TICKS    = 54,
  parameter int GAP_TICKS    = 20,
  parameter int SETTLE_TICKS = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic              cmd_page,
  input  logic              cmd_pwd_en,
  input  logic [PWD_W-1:0]  cmd_pwd,
  input  logic              cmd_lock,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              field_on,
  output logic              done,
  output logic              capture_en
);
  localparam int FRAME_W = OP_W + 1 + PWD_W + 1 + DATA_W + ADDR_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int MAX_T   = max2(max2(max2(HOLD_TICKS, START_TICKS), max2(ZERO_TICKS, ONE_TICKS)),
                                max2(GAP_TICKS, SETTLE_TICKS));
  localparam int CNT_W   = $clog2(MAX_T + 1);

  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               tm_load, expire, sh_load, sh_shift, cur_bit, empty;
  logic [CNT_W-1:0]   tm_val;

  pgap_frame_build #(
    .OP_W(OP_W), .PWD_W(PWD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) u_build (
    .wr(cmd_write), .pwd_en(cmd_pwd_en), .op(cmd_op), .page(cmd_page),
    .pwd(cmd_pwd), .lock(cmd_lock), .data(cmd_data), .addr(cmd_addr),
    .frame(frame), .len(len)
  );

  pgap_bit_shift #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .frame_in(frame), .len_in(len),
    .shift(sh_shift), .cur_bit(cur_bit), .empty(empty)
  );

  pgap_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val),
    .tick(tick), .expire(expire)
  );

  pgap_seq_ctrl #(
    .CNT_W(CNT_W), .HOLD_TICKS(HOLD_TICKS), .START_TICKS(START_TICKS),
    .ZERO_TICKS(ZERO_TICKS), .ONE_TICKS(ONE_TICKS), .GAP_TICKS(GAP_TICKS),
    .SETTLE_TICKS(SETTLE_TICKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .expire(expire), .cur_bit(cur_bit), .empty(empty), .cmd_ready(cmd_ready),
    .tm_load(tm_load), .tm_val(tm_val), .sh_load(sh_load), .sh_shift(sh_shift),
    .field_on(field_on), .done(done), .capture_en(capture_en)
  );
endmodule

// File: rtl/pgap_downlink_chk.sv
module pgap_downlink_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic field_on,
  input logic done,
  input logic capture_en
);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  capture_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |-> done);
  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(cmd_valid && cmd_ready)) |=> ($stable(field_on) && !done));
  // R10
  park_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (field_on && cmd_ready));
endmodule

bind pgap_downlink_tx pgap_downlink_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .field_on(field_on), .done(done), .capture_en(capture_en)
);

// File: tb/tb_pgap_downlink_tx.sv
module tb_pgap_downlink_tx;
  localparam int HOLD = 40, STRT = 50, T0 = 24, T1 = 54, GAP = 20, SETL = 150;

  logic clk = 0, rst_n = 0, tick = 0, cmd_valid = 0;
  logic cmd_ready, field_on, done, capture_en;
  logic cmd_write = 0, cmd_page = 0, cmd_pwd_en = 0, cmd_lock = 0;
  logic [1:0]  cmd_op = 0;
  logic [31:0] cmd_pwd = 0, cmd_data = 0;
  logic [2:0]  cmd_addr = 0;

  pgap_downlink_tx #(.HOLD_TICKS(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_op(cmd_op), .cmd_page(cmd_page), .cmd_pwd_en(cmd_pwd_en),
    .cmd_pwd(cmd_pwd), .cmd_lock(cmd_lock), .cmd_data(cmd_data), .cmd_addr(cmd_addr),
    .field_on(field_on), .done(done), .capture_en(capture_en)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit dense = 1, hold_tick = 0;
  int seg_len[0:255];
  bit seg_lvl[0:255];
  int nseg, total, n;
  bit trk = 0, fin = 0;
  int wave_err, early_err, rdy_err, wv_n;
  bit wv_act, done_val, cap_val, rdy_at_done, fld_at_done;

  always @(negedge clk) tick <= hold_tick ? 1'b0 : (dense ? 1'b1 : 1'($urandom_range(0, 1)));

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add_seg(bit lvl, int len);
    seg_lvl[nseg] = lvl; seg_len[nseg] = len; nseg++; total += len;
  endtask
  task automatic add_bit(bit b);
    add_seg(1, b ? T1 : T0); add_seg(0, GAP);
  endtask

  // R5 frame order model
  task automatic build(bit wr, bit [1:0] op, bit pg, bit pe, bit [31:0] pw, bit lk,
                       bit [31:0] d, bit [2:0] a);
    nseg = 0; total = 0;
    add_seg(1, HOLD); add_seg(0, STRT);
    add_bit(op[1]); add_bit(op[0]); add_bit(pg);
    if (pe) for (int i = 31; i >= 0; i--) add_bit(pw[i]);
    if (wr) begin
      add_bit(lk);
      for (int i = 31; i >= 0; i--) add_bit(d[i]);
    end
    for (int i = 2; i >= 0; i--) add_bit(a[i]);
    if (!wr) add_seg(1, SETL);
  endtask

  function automatic bit exp_lvl(int t);
    int acc = 0;
    for (int i = 0; i < nseg; i++) begin
      acc += seg_len[i];
      if (t < acc) return seg_lvl[i];
    end
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (trk && tick) n++;
    if (cmd_valid && cmd_ready && !trk && !fin) begin
      trk = 1; n = 0;
    end
  end

  always @(negedge clk) begin
    if (trk) begin
      if (n < total) begin
        if (field_on !== exp_lvl(n)) begin
          if (wave_err == 0) begin wv_act = field_on; wv_n = n; end
          wave_err++;
        end
        if (done !== 1'b0 || capture_en !== 1'b0) early_err++;
        if (cmd_ready !== 1'b0) rdy_err++;
      end else begin
        done_val = done; cap_val = capture_en; rdy_at_done = cmd_ready;
        fld_at_done = field_on; trk = 0; fin = 1;
      end
    end
  end

  task automatic do_cmd(bit wr, bit [1:0] op, bit pg, bit pe, bit [31:0] pw, bit lk,
                        bit [31:0] d, bit [2:0] a);
    build(wr, op, pg, pe, pw, lk, d, a);
    wave_err = 0; early_err = 0; rdy_err = 0; fin = 0;
    @(negedge clk);
    cmd_write = wr; cmd_op = op; cmd_page = pg; cmd_pwd_en = pe; cmd_pwd = pw;
    cmd_lock = lk; cmd_data = d; cmd_addr = a; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    while (!fin) @(negedge clk);
    fin = 0;
    check(wave_err == 0, "R3 R4 R5 field waveform (first bad tick value)", wv_act, !wv_act);
    check(early_err == 0, "R6 R7 no done before end", early_err, 0);
    check(done_val == 1'b1, wr ? "R6 write done pulse" : "R7 read done pulse", done_val, 1);
    check(cap_val == !wr, "R7 capture_en with done on read only", cap_val, !wr);
    check(rdy_err == 0 && rdy_at_done == 1'b1, "R2 ready low while busy, high at done", rdy_err, 0);
    check(fld_at_done == 1'b1, "R10 field parked on after command", fld_at_done, 1);
    @(negedge clk);
    check(done == 1'b0 && capture_en == 1'b0, "R6 done lasts one clock", done, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R10 reset state
    check(field_on == 1'b0, "R1 R10 field off after reset", field_on, 0);
    check(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    check(done == 1'b0 && capture_en == 1'b0, "R1 pulses low after reset", done, 0);

    // directed corners
    do_cmd(1, 2'b10, 0, 0, 32'h0, 0, 32'h0000_0000, 3'b000);
    do_cmd(0, 2'b11, 1, 1, 32'hFFFF_FFFF, 1, 32'h0, 3'b111);
    do_cmd(1, 2'b01, 1, 1, 32'h8000_0001, 1, 32'hA5C3_0F01, 3'b100);

    // R8 tick stall in the middle of a command
    dense = 0;
    fork
      do_cmd(0, 2'b10, 0, 1, 32'h1234_5678, 0, 32'h0, 3'b011);
      begin
        bit f0;
        int stall_err = 0;
        repeat (400) @(negedge clk);
        hold_tick = 1;
        repeat (2) @(negedge clk);
        f0 = field_on;
        for (int i = 0; i < 30; i++) begin
          @(negedge clk);
          if (field_on !== f0 || done !== 1'b0) stall_err++;
        end
        hold_tick = 0;
        check(stall_err == 0, "R8 frozen without tick", stall_err, 0);
      end
    join
    dense = 1;

    // R9 commands offered while busy
    fork
      do_cmd(1, 2'b10, 1, 0, 32'h0, 1, 32'h0F0F_F0F0, 3'b101);
      begin
        int rb = 0;
        repeat (200) @(negedge clk);
        cmd_write = 0; cmd_op = 2'b00; cmd_pwd_en = 1; cmd_pwd = 32'hDEAD_BEEF;
        cmd_addr = 3'b010; cmd_valid = 1;
        for (int i = 0; i < 60; i++) begin
          @(negedge clk);
          if (cmd_ready !== 1'b0) rb++;
        end
        cmd_valid = 0;
        check(rb == 0, "R9 R2 ready stays low for busy offer", rb, 0);
      end
    join
    begin
      int moved = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (field_on !== 1'b1 || cmd_ready !== 1'b1) moved++;
      end
      check(moved == 0, "R9 busy offer never started", moved, 0);
    end

    // random commands with random tick density
    for (int k = 0; k < 7; k++) begin
      dense = ($urandom_range(0, 2) != 0);
      do_cmd(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), $urandom, 1'($urandom_range(0, 1)), $urandom,
             3'($urandom_range(0, 7)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule